// File: doc/BRIEF.md
# Two-Port Shared Memory with Mailbox Interrupts

This block is a synchronous shared memory that two agents, called left and right, reach through independent ports on a common clock. Each port has an active-low select, a read/write direction bit (high for read, low for write), an active-low output enable, an address, write data and an active-low busy input. Each port returns registered read data with a valid strobe, which stands in for a driven data bus. When the strobe is low the data is forced to zero.

The two highest addresses also act as doorbells between the agents. A left write to the top word posts an interrupt to the right agent. A right write to the word just below it posts an interrupt to the left agent. An agent acknowledges its interrupt by reading its own doorbell word. Both words also keep the written byte, so a doorbell can carry a one-byte message. A low busy input on a port blocks that port's writes and its doorbell effects. An external collision arbiter drives the busy inputs.

Top module: `mailbox_dpram`

## Requirements
- R1: A port access with select low and direction low writes the write data to the addressed word. A port access with select low, direction high and output enable low returns that word on the port's read data, with valid high, one clock later.
- R2: While a port's select is high, that port writes nothing, and one clock later its valid is low and its read data is zero.
- R3: A selected read with output enable high produces no output: valid is low and read data is zero one clock later. Valid is high only in the cycle after a real read.
- R4: A left write to the top address (all address bits one) with busy high drives the right interrupt output low from the next clock. The left interrupt output is not affected.
- R5: A right read (select low, direction high, output enable low) of the top address with busy high returns the right interrupt output high from the next clock. Right reads of other addresses, left reads of the top address, and right accesses with output enable high leave it low.
- R6: A right write to the top address minus one with busy high drives the left interrupt output low. A left read of that address with busy high clears it.
- R7: While a port's busy input is low, its write is discarded and it neither sets nor clears an interrupt flag. Its reads still return data.
- R8: During reset both interrupt outputs are high, both valid outputs are low and both read data outputs are zero.
- R9: When the same clock both sets and clears an interrupt flag, the flag ends up set.
- R10: The two doorbell addresses store the written byte like any other word, and reads of them return the last byte written.
- R11: A read in the same clock as a write from the other port to that address returns the old contents. When both ports write one address in the same clock, the right port's byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rstN | input | 1 | Active-low synchronous reset |
| lCeN | input | 1 | Left select, active low |
| lRwN | input | 1 | Left direction: 1 read, 0 write |
| lOeN | input | 1 | Left output enable, active low |
| lAddr | input | ADDR_W | Left address |
| lWrData | input | DATA_W | Left write data |
| lBusyN | input | 1 | Left busy, active low, blocks writes and flag changes |
| lRdData | output | DATA_W | Left read data, zero when not valid |
| lRdValid | output | 1 | Left read data is driven |
| lIntN | output | 1 | Left interrupt, active low |
| rCeN | input | 1 | Right select, active low |
| rRwN | input | 1 | Right direction: 1 read, 0 write |
| rOeN | input | 1 | Right output enable, active low |
| rAddr | input | ADDR_W | Right address |
| rWrData | input | DATA_W | Right write data |
| rBusyN | input | 1 | Right busy, active low, blocks writes and flag changes |
| rRdData | output | DATA_W | Right read data, zero when not valid |
| rRdValid | output | 1 | Right read data is driven |
| rIntN | output | 1 | Right interrupt, active low |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 8, so the memory has 16 words and the doorbells sit at addresses 15 and 14. With so few words, every address can be written from one port and read back from the other in both directions. These sweeps pass over both doorbells, so each flag is set and cleared by the ordinary traffic. Targeted sequences then cover busy blocking, set-over-clear priority, read-old on same-address traffic and the right-wins write ordering.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Per-port strobes produced by the control and consumed by the datapath.
  typedef struct packed {
    logic wr;   // commit write data to the array
    logic rd;   // launch a registered read
  } port_stb_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCeN,
  input  logic              lRwN,
  input  logic              lOeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lBusyN,
  input  logic              rCeN,
  input  logic              rRwN,
  input  logic              rOeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rBusyN,
  output port_stb_t         lStb,
  output port_stb_t         rStb,
  output logic              lIntN,
  output logic              rIntN
);
  localparam logic [ADDR_W-1:0] RIGHT_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LEFT_BOX  = RIGHT_BOX - 1'b1;

  logic lWrReq, rWrReq, lRdReq, rRdReq;
  logic rightSet, rightClr, leftSet, leftClr;
  logic rightFlag, leftFlag;

  always_comb begin
    lWrReq = !lCeN && !lRwN && lBusyN;
    rWrReq = !rCeN && !rRwN && rBusyN;
    lRdReq = !lCeN && lRwN && !lOeN;
    rRdReq = !rCeN && rRwN && !rOeN;

    lStb.wr = lWrReq;
    lStb.rd = lRdReq;
    rStb.wr = rWrReq;
    rStb.rd = rRdReq;

    // Writer posts to the opposite side; reader acknowledges its own box.
    rightSet = lWrReq && (lAddr == RIGHT_BOX);
    rightClr = rRdReq && rBusyN && (rAddr == RIGHT_BOX);
    leftSet  = rWrReq && (rAddr == LEFT_BOX);
    leftClr  = lRdReq && lBusyN && (lAddr == LEFT_BOX);
  end

  // Set has priority over clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rightFlag <= 1'b0;
      leftFlag  <= 1'b0;
    end else begin
      if (rightSet)      rightFlag <= 1'b1;
      else if (rightClr) rightFlag <= 1'b0;
      if (leftSet)       leftFlag  <= 1'b1;
      else if (leftClr)  leftFlag  <= 1'b0;
    end
  end

  assign rIntN = !rightFlag;
  assign lIntN = !leftFlag;
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  port_stb_t         lStb,
  input  port_stb_t         rStb,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] lWrData,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic              lRdValid,
  output logic [DATA_W-1:0] rRdData,
  output logic              rRdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Right write is applied last, so it wins on a shared address.
  always_ff @(posedge clk) begin
    if (lStb.wr) store[lAddr] <= lWrData;
    if (rStb.wr) store[rAddr] <= rWrData;
  end

  // Registered reads see the array before this cycle's writes.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lRdData  <= '0;
      lRdValid <= 1'b0;
      rRdData  <= '0;
      rRdValid <= 1'b0;
    end else begin
      lRdValid <= lStb.rd;
      rRdValid <= rStb.rd;
      lRdData  <= lStb.rd ? store[lAddr] : '0;
      rRdData  <= rStb.rd ? store[rAddr] : '0;
    end
  end
endmodule

// File: rtl/mailbox_dpram.sv
module mailbox_dpram
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCeN,
  input  logic              lRwN,
  input  logic              lOeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  input  logic              lBusyN,
  output logic [DATA_W-1:0] lRdData,
  output logic              lRdValid,
  output logic              lIntN,
  input  logic              rCeN,
  input  logic              rRwN,
  input  logic              rOeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  input  logic              rBusyN,
  output logic [DATA_W-1:0] rRdData,
  output logic              rRdValid,
  output logic              rIntN
);
  port_stb_t lStb, rStb;

  mbx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lCeN(lCeN), .lRwN(lRwN), .lOeN(lOeN), .lAddr(lAddr), .lBusyN(lBusyN),
    .rCeN(rCeN), .rRwN(rRwN), .rOeN(rOeN), .rAddr(rAddr), .rBusyN(rBusyN),
    .lStb(lStb), .rStb(rStb), .lIntN(lIntN), .rIntN(rIntN)
  );

  mbx_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .lStb(lStb), .rStb(rStb),
    .lAddr(lAddr), .rAddr(rAddr), .lWrData(lWrData), .rWrData(rWrData),
    .lRdData(lRdData), .lRdValid(lRdValid),
    .rRdData(rRdData), .rRdValid(rRdValid)
  );
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              lCeN,
  input logic              lRwN,
  input logic              lOeN,
  input logic [ADDR_W-1:0] lAddr,
  input logic              lBusyN,
  input logic [DATA_W-1:0] lRdData,
  input logic              lRdValid,
  input logic              lIntN,
  input logic              rCeN,
  input logic              rRwN,
  input logic              rOeN,
  input logic [ADDR_W-1:0] rAddr,
  input logic              rBusyN,
  input logic [DATA_W-1:0] rRdData,
  input logic              rRdValid,
  input logic              rIntN
);
  localparam logic [ADDR_W-1:0] TOPA = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXTA = TOPA - 1'b1;

  // R8
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (lIntN && rIntN && !lRdValid && !rRdValid));

  // R1
  left_read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lCeN && lRwN && !lOeN) |=> lRdValid);

  // R3
  left_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!lCeN && lRwN && !lOeN) |=> (!lRdValid && lRdData == '0));

  // R2
  right_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rCeN |=> (!rRdValid && rRdData == '0));

  // R4
  right_post_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lBusyN && !lCeN && !lRwN && lAddr == TOPA) |=> !rIntN);

  // R6
  left_post_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rBusyN && !rCeN && !rRwN && rAddr == NEXTA) |=> !lIntN);

  // R5
  right_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rBusyN && !rCeN && rRwN && !rOeN && rAddr == TOPA &&
     !(lBusyN && !lCeN && !lRwN && lAddr == TOPA)) |=> rIntN);

  // R7
  right_busy_no_post_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rBusyN |=> !$fell(lIntN));

  // R7
  right_busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rBusyN |=> !$rose(rIntN));

  // R7
  left_busy_no_post_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lBusyN |=> !$fell(rIntN));
endmodule

bind mailbox_dpram mbx_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .lCeN(lCeN), .lRwN(lRwN), .lOeN(lOeN), .lAddr(lAddr), .lBusyN(lBusyN),
  .lRdData(lRdData), .lRdValid(lRdValid), .lIntN(lIntN),
  .rCeN(rCeN), .rRwN(rRwN), .rOeN(rOeN), .rAddr(rAddr), .rBusyN(rBusyN),
  .rRdData(rRdData), .rRdValid(rRdValid), .rIntN(rIntN)
);

// File: tb/mailbox_dpram_bench.sv
module mailbox_dpram_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NW = 1 << AW;
  localparam int TOPA = NW - 1;
  localparam int NEXTA = NW - 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lCeN, lRwN, lOeN, lBusyN, rCeN, rRwN, rOeN, rBusyN;
  logic [AW-1:0] lAddr, rAddr;
  logic [DW-1:0] lWrData, rWrData, lRdData, rRdData;
  logic lRdValid, rRdValid, lIntN, rIntN;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mailbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) u_mailbox_dpram (
    .clk(clk), .rstN(rstN),
    .lCeN(lCeN), .lRwN(lRwN), .lOeN(lOeN), .lAddr(lAddr), .lWrData(lWrData),
    .lBusyN(lBusyN), .lRdData(lRdData), .lRdValid(lRdValid), .lIntN(lIntN),
    .rCeN(rCeN), .rRwN(rRwN), .rOeN(rOeN), .rAddr(rAddr), .rWrData(rWrData),
    .rBusyN(rBusyN), .rRdData(rRdData), .rRdValid(rRdValid), .rIntN(rIntN)
  );

  function automatic logic [DW-1:0] leftPat(int a);
    return DW'((a * 37 + 5) & 8'hFF);
  endfunction
  function automatic logic [DW-1:0] rightPat(int a);
    return DW'((a * 91 + 200) & 8'hFF);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lCeN = 1; lRwN = 1; lOeN = 1; lBusyN = 1; lAddr = '0; lWrData = '0;
    rCeN = 1; rRwN = 1; rOeN = 1; rBusyN = 1; rAddr = '0; rWrData = '0;
  endtask
  task automatic lWrite(int a, logic [DW-1:0] d);
    lCeN = 0; lRwN = 0; lAddr = AW'(a); lWrData = d;
  endtask
  task automatic rWrite(int a, logic [DW-1:0] d);
    rCeN = 0; rRwN = 0; rAddr = AW'(a); rWrData = d;
  endtask
  task automatic lRead(int a);
    lCeN = 0; lRwN = 1; lOeN = 0; lAddr = AW'(a);
  endtask
  task automatic rRead(int a);
    rCeN = 0; rRwN = 1; rOeN = 0; rAddr = AW'(a);
  endtask
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) tick();
    check("R8 rIntN", rIntN, 1);
    check("R8 lIntN", lIntN, 1);
    check("R8 valids", {lRdValid, rRdValid}, 0);
    check("R8 data", {lRdData, rRdData}, 0);
    rstN = 1;
    tick();

    // R1 / R10: left fills every word, right reads them back.
    for (int a = 0; a < NW; a++) begin
      idle(); lWrite(a, leftPat(a)); tick();
    end
    check("R4 right flag after sweep", rIntN, 0);
    for (int a = 0; a < NW; a++) begin
      idle(); rRead(a); tick();
      check(a >= NEXTA ? "R10 right read box" : "R1 right read", rRdData, leftPat(a));
      check("R1 right valid", rRdValid, 1);
    end
    check("R5 right flag cleared by sweep", rIntN, 1);
    idle(); tick();
    check("R3 valid drops after read", rRdValid, 0);

    // R1 / R10: right fills, left reads.
    for (int a = 0; a < NW; a++) begin
      idle(); rWrite(a, rightPat(a)); tick();
    end
    check("R6 left flag after sweep", lIntN, 0);
    check("R6 right flag unchanged", rIntN, 1);
    for (int a = 0; a < NW; a++) begin
      idle(); lRead(a); tick();
      check(a >= NEXTA ? "R10 left read box" : "R1 left read", lRdData, rightPat(a));
      check("R1 left valid", lRdValid, 1);
    end
    check("R6 left flag cleared by sweep", lIntN, 1);

    // R2: deselected port.
    idle(); lCeN = 1; lRwN = 0; lAddr = 3; lWrData = 8'hAA; tick();
    check("R2 left deselected valid", lRdValid, 0);
    idle(); rRead(3); tick();
    check("R2 deselected write ignored", rRdData, rightPat(3));
    idle(); rCeN = 1; rRwN = 1; rOeN = 0; rAddr = 3; tick();
    check("R2 right deselected valid", rRdValid, 0);
    check("R2 right deselected data", rRdData, 0);

    // R3: output enable high.
    idle(); lRead(5); lOeN = 1; tick();
    check("R3 oe high valid", lRdValid, 0);
    check("R3 oe high data", lRdData, 0);

    // R4 / R5
    idle(); lWrite(TOPA, 8'h5A); tick();
    check("R4 right int low", rIntN, 0);
    check("R4 left int untouched", lIntN, 1);
    idle(); lRead(TOPA); tick();
    check("R10 left reads box", lRdData, 8'h5A);
    check("R5 left read keeps flag", rIntN, 0);
    idle(); rRead(3); tick();
    check("R5 other address keeps flag", rIntN, 0);
    idle(); rRead(TOPA); rOeN = 1; tick();
    check("R5 oe high keeps flag", rIntN, 0);
    idle(); rRead(TOPA); tick();
    check("R5 right reads box", rRdData, 8'h5A);
    check("R5 right ack clears", rIntN, 1);

    // R7: busy blocks writes and flag changes.
    idle(); lBusyN = 0; lWrite(2, 8'h11); tick();
    idle(); rRead(2); tick();
    check("R7 busy write discarded", rRdData, rightPat(2));
    idle(); lBusyN = 0; lWrite(TOPA, 8'h99); tick();
    check("R7 busy no post", rIntN, 1);
    idle(); rBusyN = 0; rWrite(NEXTA, 8'h98); tick();
    check("R7 busy no post left", lIntN, 1);
    idle(); lWrite(TOPA, 8'h77); tick();
    check("R4 post again", rIntN, 0);
    idle(); rBusyN = 0; rRead(TOPA); tick();
    check("R7 busy read still returns data", rRdData, 8'h77);
    check("R7 busy no ack", rIntN, 0);
    idle(); rRead(TOPA); tick();
    check("R5 ack after busy", rIntN, 1);
    idle(); rWrite(NEXTA, 8'h21); tick();
    idle(); lBusyN = 0; lRead(NEXTA); tick();
    check("R7 left busy no ack", lIntN, 0);
    idle(); lRead(NEXTA); tick();
    check("R6 left ack", lIntN, 1);

    // R9 / R11: set and clear together, read returns old byte.
    idle(); lWrite(TOPA, 8'h33); tick();
    idle(); lWrite(TOPA, 8'h44); rRead(TOPA); tick();
    check("R9 set wins", rIntN, 0);
    check("R11 read returns old", rRdData, 8'h33);
    idle(); rRead(TOPA); tick();
    check("R10 new byte", rRdData, 8'h44);
    check("R5 clear after tie", rIntN, 1);

    // R11: both ports write one word.
    idle(); lWrite(6, 8'h12); rWrite(6, 8'h34); tick();
    idle(); lRead(6); tick();
    check("R11 right write kept", lRdData, 8'h34);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule